// File: doc/BRIEF.md
# Bit-Slice Cache Data RAM with Block Substitution

This block is one slice of a direct-mapped data cache. Eight slices side by side form the whole cache. Each slice keeps 4 bits of every 32-bit cache word. It stores 32 rows of 64 bits. Internally the rows are spread over eight logical 8-bit-wide memory blocks. A ninth physical block of the same shape is a spare. Three static select pins name the one logical block whose physical array is unusable. All writes and reads for that logical block then go to the spare, so the ports behave the same for every pin setting.

A read takes a 9-bit address. The upper five bits pick the row and the lower four bits pick one 4-bit nibble of that row. The nibble appears on the output one clock later and stays there until the next read. The processor side writes a single nibble at the same address. The refill side loads a whole 64-bit row in one cycle from a wide bus, using the row index of the same address.

Tag comparison, miss handling and the next-level memory interface belong to other blocks.

Top module: `cache_slice_ram`

## Requirements
- R1: After reset is released, and before any read, `rd_nib` is 0.
- R2: When `rd_en` is high at a clock edge, `rd_nib` after that edge equals bits [4k+3:4k] of row `addr[8:4]`, where k = `addr[3:0]`.
- R3: When `rd_en` is low at a clock edge, `rd_nib` keeps its value.
- R4: A nibble write (`wr_en` high, `fill_en` low) replaces only nibble `addr[3:0]` of row `addr[8:4]` with `wr_nib`. The other 60 bits of that row and all other rows are unchanged.
- R5: A refill (`fill_en` high) replaces all 64 bits of row `addr[8:4]` with `fill_row` in one cycle. Bit i of `fill_row` becomes bit i of the row.
- R6: When `fill_en` and `wr_en` are both high in the same cycle, the refill wins and `wr_nib` has no effect.
- R7: A read in the same cycle as a write or refill to the same row returns the row contents from before that write.
- R8: For every value 0..7 of `spare_sel`, R2 to R7 hold unchanged. The named block's physical array is never written, and exactly the expected number of physical blocks is written: one for a nibble write, eight for a refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spare_sel | input | 3 | Static number of the logical block replaced by the spare |
| addr | input | 9 | Row index [8:4] and nibble select [3:0] |
| rd_en | input | 1 | Read enable, loads the output register |
| rd_nib | output | 4 | Registered read nibble |
| wr_en | input | 1 | Processor-side nibble write enable |
| wr_nib | input | 4 | Nibble write data |
| fill_en | input | 1 | Full-row refill enable |
| fill_row | input | 64 | Refill row data |

## Verification
Two collisions can fall in one cycle. The first is a read that lands on a row being written or refilled in the same cycle; the expected result is the row's old contents. The second is a nibble write together with a refill; the expected result is the refill data. Random traffic is confined to a few rows about half the time, so both collisions occur often. Directed steps also force each collision. A bench model applies the read before the write and lets the refill override the nibble write. Every one of the eight spare settings is run, and each run refills every row first.

// File: rtl/cache_slice_pkg.sv
package cache_slice_pkg;
  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_NIB  = 2'd1,
    WK_ROW  = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/slice_mem_block.sv
module slice_mem_block #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned W     = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wd,
  input  logic [W-1:0]  bm,
  output logic [W-1:0]  rd
);
  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] merged;

  always_comb merged = (mem[addr] & ~bm) | (wd & bm);

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= merged;
  end

  assign rd = mem[addr];
endmodule

// File: rtl/slice_steer.sv
module slice_steer
  import cache_slice_pkg::*;
#(
  parameter int unsigned NBLK  = 8,
  parameter int unsigned BLK_W = 8,
  parameter int unsigned NIB_W = 4,
  localparam int unsigned ROW_W = NBLK * BLK_W,
  localparam int unsigned NSEL  = ROW_W / NIB_W,
  localparam int unsigned SEL_W = $clog2(NSEL),
  localparam int unsigned SP_W  = $clog2(NBLK),
  localparam int unsigned NPB   = BLK_W / NIB_W
) (
  input  logic                         clk,
  input  logic                         rst_ok,
  input  wr_kind_e                     wkind,
  input  logic [SEL_W-1:0]             sel,
  input  logic [SP_W-1:0]              spare,
  input  logic [NIB_W-1:0]             nib_data,
  input  logic [ROW_W-1:0]             row_data,
  input  logic [NBLK:0][BLK_W-1:0]     phys_rd,
  output logic [NBLK:0]                phys_we,
  output logic [NBLK:0][BLK_W-1:0]     phys_wd,
  output logic [NBLK:0][BLK_W-1:0]     phys_bm,
  output logic [ROW_W-1:0]             log_row
);
  logic [NBLK-1:0]             lwe;
  logic [NBLK-1:0][BLK_W-1:0]  lwd;
  logic [NBLK-1:0][BLK_W-1:0]  lbm;
  logic [SEL_W-1:0]            tgt_blk;
  logic [SEL_W-1:0]            lane;

  assign tgt_blk = sel / SEL_W'(NPB);
  assign lane    = sel % SEL_W'(NPB);

  for (genvar b = 0; b < NBLK; b++) begin : g_log
    always_comb begin
      lwe[b] = 1'b0;
      lwd[b] = '0;
      lbm[b] = '0;
      if (wkind == WK_ROW) begin
        lwe[b] = 1'b1;
        lwd[b] = row_data[b*BLK_W +: BLK_W];
        lbm[b] = '1;
      end else if (wkind == WK_NIB && tgt_blk == SEL_W'(b)) begin
        lwe[b] = 1'b1;
        lwd[b] = {NPB{nib_data}};
        lbm[b][lane*NIB_W +: NIB_W] = '1;
      end
    end
    assign phys_we[b] = lwe[b] && (spare != SP_W'(b));
    assign phys_wd[b] = lwd[b];
    assign phys_bm[b] = lbm[b];
    assign log_row[b*BLK_W +: BLK_W] = (spare == SP_W'(b)) ? phys_rd[NBLK] : phys_rd[b];
  end

  assign phys_we[NBLK] = lwe[spare];
  assign phys_wd[NBLK] = lwd[spare];
  assign phys_bm[NBLK] = lbm[spare];

  // R8
  masked_idle_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !phys_we[spare]);
  // R4
  one_nib_blk_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (wkind == WK_NIB) |-> ($countones(phys_we) == 1));
  // R5
  fill_all_blk_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (wkind == WK_ROW) |-> ($countones(phys_we) == NBLK));
endmodule

// File: rtl/cache_slice_ram.sv
module cache_slice_ram
  import cache_slice_pkg::*;
#(
  parameter int unsigned ROWS  = 32,
  parameter int unsigned NBLK  = 8,
  parameter int unsigned BLK_W = 8,
  parameter int unsigned NIB_W = 4,
  localparam int unsigned ROW_W = NBLK * BLK_W,
  localparam int unsigned RA_W  = $clog2(ROWS),
  localparam int unsigned SEL_W = $clog2(ROW_W / NIB_W),
  localparam int unsigned SP_W  = $clog2(NBLK),
  localparam int unsigned A_W   = RA_W + SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SP_W-1:0]   spare_sel,
  input  logic [A_W-1:0]    addr,
  input  logic              rd_en,
  output logic [NIB_W-1:0]  rd_nib,
  input  logic              wr_en,
  input  logic [NIB_W-1:0]  wr_nib,
  input  logic              fill_en,
  input  logic [ROW_W-1:0]  fill_row
);
  logic [1:0]                 rs_q;
  logic                       rst_ok;
  wr_kind_e                   wkind;
  logic [RA_W-1:0]            row_idx;
  logic [SEL_W-1:0]           sel;
  logic [NBLK:0]              phys_we;
  logic [NBLK:0][BLK_W-1:0]   phys_wd;
  logic [NBLK:0][BLK_W-1:0]   phys_bm;
  logic [NBLK:0][BLK_W-1:0]   phys_rd;
  logic [ROW_W-1:0]           log_row;
  logic [NIB_W-1:0]           rd_d;
  logic [NIB_W-1:0]           rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ok = rs_q[1];

  assign row_idx = addr[A_W-1:SEL_W];
  assign sel     = addr[SEL_W-1:0];

  always_comb begin
    wkind = WK_NONE;
    if (rst_ok) begin
      if (fill_en)     wkind = WK_ROW;
      else if (wr_en)  wkind = WK_NIB;
    end
  end

  slice_steer #(.NBLK(NBLK), .BLK_W(BLK_W), .NIB_W(NIB_W)) u_steer (
    .clk      (clk),
    .rst_ok   (rst_ok),
    .wkind    (wkind),
    .sel      (sel),
    .spare    (spare_sel),
    .nib_data (wr_nib),
    .row_data (fill_row),
    .phys_rd  (phys_rd),
    .phys_we  (phys_we),
    .phys_wd  (phys_wd),
    .phys_bm  (phys_bm),
    .log_row  (log_row)
  );

  for (genvar p = 0; p <= NBLK; p++) begin : g_blk
    slice_mem_block #(.DEPTH(ROWS), .W(BLK_W)) u_mem (
      .clk  (clk),
      .we   (phys_we[p]),
      .addr (row_idx),
      .wd   (phys_wd[p]),
      .bm   (phys_bm[p]),
      .rd   (phys_rd[p])
    );
  end

  always_comb begin
    rd_d = rd_q;
    if (rd_en) rd_d = log_row[sel*NIB_W +: NIB_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (!rst_ok) rd_q <= '0;
    else             rd_q <= rd_d;
  end

  assign rd_nib = rd_q;

  // R3
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!rd_en && $past(rst_ok)) |=> $stable(rd_nib));
  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_ok |=> (rd_nib == '0));
endmodule

// File: tb/sim_cache_slice_ram.sv
module sim_cache_slice_ram;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  spare_sel;
  logic [8:0]  addr;
  logic        rd_en;
  logic [3:0]  rd_nib;
  logic        wr_en;
  logic [3:0]  wr_nib;
  logic        fill_en;
  logic [63:0] fill_row;

  int unsigned total = 0;
  int unsigned bad   = 0;
  logic [63:0] model [32];
  logic [3:0]  exp_out;

  always #2 clk = ~clk;

  cache_slice_ram u0 (
    .clk(clk), .rst_n(rst_n), .spare_sel(spare_sel), .addr(addr),
    .rd_en(rd_en), .rd_nib(rd_nib), .wr_en(wr_en), .wr_nib(wr_nib),
    .fill_en(fill_en), .fill_row(fill_row)
  );

  function automatic logic [3:0] nib_of(logic [63:0] row, logic [3:0] k);
    return row[k*4 +: 4];
  endfunction

  function automatic logic [63:0] rand64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s spare=%0d actual=%h expected=%h", tag, spare_sel, act, expv);
    end
  endtask

  // drive at negedge, model, wait one edge, check at next negedge
  task automatic step(string tag, logic rd, logic wr, logic fl,
                      logic [8:0] a, logic [3:0] n, logic [63:0] r);
    logic [4:0] ri;
    ri = a[8:4];
    rd_en = rd; wr_en = wr; fill_en = fl; addr = a; wr_nib = n; fill_row = r;
    if (rd) exp_out = nib_of(model[ri], a[3:0]);
    if (fl) model[ri] = r;
    else if (wr) model[ri][a[3:0]*4 +: 4] = n;
    @(posedge clk);
    @(negedge clk);
    check(rd ? tag : "R3", rd_nib, exp_out);
  endtask

  task automatic do_reset(logic [2:0] sp);
    rst_n = 1'b0; rd_en = 0; wr_en = 0; fill_en = 0; addr = '0;
    wr_nib = '0; fill_row = '0;
    spare_sel = sp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    exp_out = '0;
    check("R1", rd_nib, 4'h0);
  endtask

  initial begin
    #700000;
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int s = 0; s < 8; s++) begin
      do_reset(3'(s));
      // R8: every spare setting sees identical port behaviour
      for (int r = 0; r < 32; r++) step("R5", 1'b0, 1'b0, 1'b1, {5'(r), 4'h0}, 4'h0, rand64());
      for (int k = 0; k < 16; k++) step("R5", 1'b1, 1'b0, 1'b0, {5'd0, 4'(k)}, 4'h0, 64'h0);
      // R4 directed: one nibble changes, neighbours keep
      step("R4", 1'b0, 1'b1, 1'b0, {5'd3, 4'd7}, 4'hA ^ 4'(s), 64'h0);
      for (int k = 6; k < 9; k++) step("R4", 1'b1, 1'b0, 1'b0, {5'd3, 4'(k)}, 4'h0, 64'h0);
      // R6 directed: refill beats nibble write
      step("R6", 1'b0, 1'b1, 1'b1, {5'd5, 4'd2}, 4'hF, 64'h0123_4567_89AB_CDE0);
      step("R6", 1'b1, 1'b0, 1'b0, {5'd5, 4'd2}, 4'h0, 64'h0);
      // R7 directed: read sees old data during a write
      step("R7", 1'b1, 1'b1, 1'b0, {5'd5, 4'd2}, 4'h9, 64'h0);
      step("R7", 1'b1, 1'b0, 1'b1, {5'd5, 4'd2}, 4'h0, rand64());
      step("R2", 1'b1, 1'b0, 1'b0, {5'd5, 4'd2}, 4'h0, 64'h0);
      // random traffic, half of it on four rows
      for (int i = 0; i < 400; i++) begin
        logic rd, wr, fl;
        logic [8:0] a;
        rd = ($urandom() % 3) != 0;
        wr = ($urandom() % 3) == 0;
        fl = ($urandom() % 8) == 0;
        a  = 9'($urandom());
        if ($urandom() % 2 == 0) a[8:4] = 5'($urandom() % 4);
        step((rd && (wr || fl)) ? "R7" : "R2", rd, wr, fl, a, 4'($urandom()), rand64());
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule